// File: doc/BRIEF.md
# USB Handshake Interrupt Filter

This block sits between the transaction engine of a USB device controller and the chip's interrupt pin. Each completed handshake (ACK, NAK or NYET) arrives tagged with the endpoint class that produced it: control, data IN or data OUT. A per-class mode decides whether that handshake raises the class's interrupt request. One mode reports every handshake. One reports acknowledgements only. One reports acknowledgements plus only the first NAK that follows a SETUP token and its acknowledgement. The OUT class also treats NYET as a reportable handshake.

Requests stay pending per class until status handling clears them. The combined request drives a single pin. The pin is either a level that follows the pending requests or a fixed-width pulse per interrupt, and its active polarity is selectable. An 8-bit configuration byte, written and read over a simple register port, holds the three class modes and the two output-style bits. Bus reset disarms the first-NAK tracking.

Top module: `hs_irq_filter`

## Requirements
- R1: The configuration byte holds the control mode in bits 7:6, the IN mode in bits 5:4, the OUT mode in bits 3:2, pulsed output in bit 1 and active-high polarity in bit 0. It resets to 8'hFC. A write with `cfg_we` is visible on `cfg_rdata` from the next cycle.
- R2: Handshake codes on `hs_kind` are 0 for ACK, 1 for NAK and 2 for NYET. Class codes on `hs_class` are 0 for control, 1 for IN and 2 for OUT. A code of 3 on either input is ignored. An ACK in any class and mode sets that class's bit of `ep_irq_req` one cycle later.
- R3: In mode 00 every NAK is reported. In mode 01 no NAK is reported.
- R4: In modes 10 and 11 a NAK is reported only if its class is armed. A NAK in a class disarms that class in every mode. All three classes are armed by a control ACK that follows a `setup_tok` pulse, with a ACK and pulse in the same cycle counting as a sequence only with an earlier pulse.
- R5: NYET is reported for the OUT class in every mode. A NYET on the control or IN class has no effect.
- R6: `bus_reset` disarms all classes and cancels a SETUP still waiting for its ACK.
- R7: A set bit of `ep_irq_req` holds until the matching bit of `irq_clear` is high. A new report wins over a clear in the same cycle.
- R8: With bit 1 low, the pin is active exactly while any bit of `ep_irq_req` is set.
- R9: With bit 1 high, a report starts a pulse that is active for exactly `PULSE_CYC` cycles, starting the cycle after the report. A report during a pulse is merged into that pulse and does not lengthen it.
- R10: With bit 0 low the pin is active low. With bit 0 high it is active high. Inactive is the opposite level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | USB bus reset seen, disarms first-NAK tracking |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| setup_tok | input | 1 | SETUP token received (one-cycle pulse) |
| hs_valid | input | 1 | Handshake completed this cycle |
| hs_kind | input | 2 | Handshake code (0 ACK, 1 NAK, 2 NYET) |
| hs_class | input | 2 | Endpoint class (0 control, 1 IN, 2 OUT) |
| irq_clear | input | 3 | Per-class acknowledge of pending requests |
| ep_irq_req | output | 3 | Per-class pending interrupt requests |
| irq_pin | output | 1 | Shaped interrupt output |

## Verification
The main sweep covers every mode in every class with every handshake code. Each combination is sent twice after a SETUP-and-ACK arming sequence. The first send separates the report rules of the three modes and the NYET rule of the OUT class. The second send separates the single first NAK from repeated NAKs. Further patterns arm the classes and then spend the arming in one class only, to show the tracking flags are independent, and issue bus reset between arming and a NAK. A clear is driven in the same cycle as a report to check that the report wins. Pulse mode is tried with one isolated report and with a second report inside the pulse, which distinguishes merging from retriggering. Both polarities are checked in the idle state.

// File: rtl/hs_irq_pkg.sv
package hs_irq_pkg;

   localparam int NUM_CLS = 3;

   localparam logic [1:0] KIND_ACK  = 2'd0;
   localparam logic [1:0] KIND_NAK  = 2'd1;
   localparam logic [1:0] KIND_NYET = 2'd2;

   localparam logic [1:0] CLS_CTRL = 2'd0;
   localparam logic [1:0] CLS_IN   = 2'd1;
   localparam logic [1:0] CLS_OUT  = 2'd2;

   // Field order matches the register bit positions (MSB first).
   typedef struct packed {
      logic [1:0] ctl_mode;
      logic [1:0] in_mode;
      logic [1:0] out_mode;
      logic       pulsed;
      logic       act_high;
   } hs_cfg_t;

endpackage

// File: rtl/hs_cfg_reg.sv
module hs_cfg_reg
   import hs_irq_pkg::*;
#(
   parameter int          CFG_W   = 8,
   parameter logic [7:0]  CFG_RST = 8'hFC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [CFG_W-1:0] wdata_i,
   output logic [CFG_W-1:0] rdata_o,
   output hs_cfg_t          cfg_o
);

   if (CFG_W != $bits(hs_cfg_t)) begin : g_bad_width
      $error("hs_cfg_reg: CFG_W must equal the packed config width");
   end

   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RST[CFG_W-1:0];
      end else if (we_i) begin
         cfg_q <= wdata_i;
      end
   end

   assign rdata_o = cfg_q;
   assign cfg_o   = hs_cfg_t'(cfg_q);

   AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (rdata_o == $past(wdata_i)));  // R1

endmodule

// File: rtl/hs_nak_tracker.sv
module hs_nak_tracker
   import hs_irq_pkg::*;
#(
   parameter int NCLS = NUM_CLS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_reset_i,
   input  logic            setup_tok_i,
   input  logic            hs_valid_i,
   input  logic [1:0]      hs_kind_i,
   input  logic [1:0]      hs_class_i,
   output logic [NCLS-1:0] armed_o
);

   if (NCLS < 1 || NCLS > 4) begin : g_bad_ncls
      $error("hs_nak_tracker: NCLS out of range");
   end

   logic            setup_wait_q;
   logic            ctl_ack;
   logic            arm_evt;
   logic [NCLS-1:0] armed_q;
   logic [NCLS-1:0] nak_hit;

   assign ctl_ack = hs_valid_i && (hs_kind_i == KIND_ACK) && (hs_class_i == CLS_CTRL);
   assign arm_evt = ctl_ack && setup_wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_wait_q <= 1'b0;
      end else if (bus_reset_i) begin
         setup_wait_q <= 1'b0;
      end else if (setup_tok_i) begin
         setup_wait_q <= 1'b1;
      end else if (ctl_ack) begin
         setup_wait_q <= 1'b0;
      end
   end

   for (genvar c = 0; c < NCLS; c++) begin : g_flag
      assign nak_hit[c] = hs_valid_i && (hs_kind_i == KIND_NAK) && (hs_class_i == 2'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed_q[c] <= 1'b0;
         end else if (bus_reset_i) begin
            armed_q[c] <= 1'b0;
         end else if (arm_evt) begin
            armed_q[c] <= 1'b1;
         end else if (nak_hit[c]) begin
            armed_q[c] <= 1'b0;
         end
      end

      AST_NAK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
         (nak_hit[c] && !bus_reset_i) |=> !armed_q[c]);  // R4
   end

   assign armed_o = armed_q;

   AST_BUSRST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_i |=> (armed_q == '0));  // R6

endmodule

// File: rtl/hs_class_filter.sv
module hs_class_filter
   import hs_irq_pkg::*;
#(
   parameter logic [1:0] CLS_ID   = 2'd0,
   parameter bit         NYET_REP = 1'b0
) (
   input  logic       hs_valid_i,
   input  logic [1:0] hs_kind_i,
   input  logic [1:0] hs_class_i,
   input  logic [1:0] mode_i,
   input  logic       armed_i,
   output logic       report_o
);

   logic hit;
   logic nak_ok;
   logic nyet_ok;

   assign hit = hs_valid_i && (hs_class_i == CLS_ID);

   always_comb begin
      unique case (mode_i)
         2'b00:   nak_ok = 1'b1;
         2'b01:   nak_ok = 1'b0;
         default: nak_ok = armed_i;
      endcase
   end

   if (NYET_REP) begin : g_nyet_on
      assign nyet_ok = 1'b1;
   end else begin : g_nyet_off
      assign nyet_ok = 1'b0;
   end

   always_comb begin
      report_o = 1'b0;
      if (hit) begin
         unique case (hs_kind_i)
            KIND_ACK:  report_o = 1'b1;
            KIND_NAK:  report_o = nak_ok;
            KIND_NYET: report_o = nyet_ok;
            default:   report_o = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/hs_irq_shaper.sv
module hs_irq_shaper #(
   parameter int NCLS      = 3,
   parameter int PULSE_CYC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCLS-1:0] report_i,
   input  logic [NCLS-1:0] clr_i,
   input  logic            pulsed_i,
   input  logic            act_high_i,
   output logic [NCLS-1:0] pend_o,
   output logic            pin_o
);

   localparam int CNT_W = $clog2(PULSE_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("hs_irq_shaper: PULSE_CYC must be at least 1");
   end

   logic [NCLS-1:0]  pend_q;
   logic [CNT_W-1:0] cnt_q;
   logic             any_rep;
   logic             active;

   assign any_rep = |report_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         pend_q <= (pend_q & ~clr_i) | report_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (any_rep && pulsed_i) begin
         cnt_q <= CNT_LOAD;
      end
   end

   assign active = pulsed_i ? (cnt_q != '0) : (|pend_q);
   assign pin_o  = act_high_i ? active : ~active;
   assign pend_o = pend_q;

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((($past(pend_q) & ~$past(clr_i)) | $past(report_i)) & ~pend_q) == '0));  // R7

   AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LOAD);  // R9

   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (pulsed_i && any_rep && cnt_q == '0) |=> (cnt_q == CNT_LOAD));  // R9

endmodule

// File: rtl/hs_irq_filter.sv
module hs_irq_filter
   import hs_irq_pkg::*;
#(
   parameter int          PULSE_CYC = 4,
   parameter logic [7:0]  CFG_RST   = 8'hFC
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_reset,
   input  logic       cfg_we,
   input  logic [7:0] cfg_wdata,
   output logic [7:0] cfg_rdata,
   input  logic       setup_tok,
   input  logic       hs_valid,
   input  logic [1:0] hs_kind,
   input  logic [1:0] hs_class,
   input  logic [2:0] irq_clear,
   output logic [2:0] ep_irq_req,
   output logic       irq_pin
);

   localparam int NCLS = NUM_CLS;

   hs_cfg_t         cfg;
   logic [NCLS-1:0] armed;
   logic [NCLS-1:0] report;
   logic [1:0]      mode [NCLS];

   assign mode[0] = cfg.ctl_mode;
   assign mode[1] = cfg.in_mode;
   assign mode[2] = cfg.out_mode;

   hs_cfg_reg #(
      .CFG_W   (8),
      .CFG_RST (CFG_RST)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we),
      .wdata_i (cfg_wdata),
      .rdata_o (cfg_rdata),
      .cfg_o   (cfg)
   );

   hs_nak_tracker #(
      .NCLS (NCLS)
   ) u_trk (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_reset_i (bus_reset),
      .setup_tok_i (setup_tok),
      .hs_valid_i  (hs_valid),
      .hs_kind_i   (hs_kind),
      .hs_class_i  (hs_class),
      .armed_o     (armed)
   );

   for (genvar c = 0; c < NCLS; c++) begin : g_cls
      hs_class_filter #(
         .CLS_ID   (2'(c)),
         .NYET_REP (c == int'(CLS_OUT))
      ) u_flt (
         .hs_valid_i (hs_valid),
         .hs_kind_i  (hs_kind),
         .hs_class_i (hs_class),
         .mode_i     (mode[c]),
         .armed_i    (armed[c]),
         .report_o   (report[c])
      );

      AST_ACK_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
         (hs_valid && hs_kind == KIND_ACK && hs_class == 2'(c)) |=> ep_irq_req[c]);  // R2

      AST_MODE01_NO_NAK: assert property (@(posedge clk) disable iff (!rst_n)
         (hs_valid && hs_kind == KIND_NAK && hs_class == 2'(c) && mode[c] == 2'b01
          && !ep_irq_req[c]) |=> !ep_irq_req[c]);  // R3

      if (c != int'(CLS_OUT)) begin : g_nyet_chk
         AST_NYET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (hs_valid && hs_kind == KIND_NYET && hs_class == 2'(c) && !ep_irq_req[c])
            |=> !ep_irq_req[c]);  // R5
      end
   end

   hs_irq_shaper #(
      .NCLS      (NCLS),
      .PULSE_CYC (PULSE_CYC)
   ) u_shp (
      .clk        (clk),
      .rst_n      (rst_n),
      .report_i   (report),
      .clr_i      (irq_clear),
      .pulsed_i   (cfg.pulsed),
      .act_high_i (cfg.act_high),
      .pend_o     (ep_irq_req),
      .pin_o      (irq_pin)
   );

   AST_LEVEL_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.pulsed |-> (irq_pin == (cfg.act_high ? (|ep_irq_req) : !(|ep_irq_req))));  // R8

endmodule

// File: tb/hs_irq_filter_tb.sv
module hs_irq_filter_tb;

   localparam int PULSE_CYC = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_reset = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       setup_tok = 1'b0;
   logic       hs_valid = 1'b0;
   logic [1:0] hs_kind = '0;
   logic [1:0] hs_class = '0;
   logic [2:0] irq_clear = '0;
   logic [2:0] ep_irq_req;
   logic       irq_pin;

   int n_cmp = 0;
   int n_bad = 0;
   logic [2:0] m_armed = '0;

   always #4 clk = ~clk;

   hs_irq_filter #(.PULSE_CYC(PULSE_CYC), .CFG_RST(8'hFC)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .setup_tok(setup_tok), .hs_valid(hs_valid), .hs_kind(hs_kind),
      .hs_class(hs_class), .irq_clear(irq_clear),
      .ep_irq_req(ep_irq_req), .irq_pin(irq_pin)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wcfg(input logic [7:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic hs(input logic [1:0] cls, input logic [1:0] kind);
      @(negedge clk); hs_valid = 1'b1; hs_class = cls; hs_kind = kind;
      @(negedge clk); hs_valid = 1'b0;
      if (kind == 2'd1 && cls != 2'd3) m_armed[cls] = 1'b0;
   endtask

   task automatic clr_all();
      @(negedge clk); irq_clear = 3'b111;
      @(negedge clk); irq_clear = 3'b000;
   endtask

   task automatic arm();
      @(negedge clk); setup_tok = 1'b1;
      @(negedge clk); setup_tok = 1'b0;
      hs(2'd0, 2'd0);
      m_armed = 3'b111;
      clr_all();
   endtask

   function automatic logic exp_rep(input int mode, input int cls, input int kind, input logic armed);
      if (kind == 0) return 1'b1;
      if (kind == 2) return (cls == 2);
      if (mode == 0) return 1'b1;
      if (mode == 1) return 1'b0;
      return armed;
   endfunction

   task automatic count_pulse(output int n);
      n = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (irq_pin == 1'b0) n++;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int np;
      logic e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset cfg", 32'(cfg_rdata), 32'hFC);
      check("R7 reset pend", 32'(ep_irq_req), 32'h0);
      check("R10 idle active-low pin", 32'(irq_pin), 32'h1);

      wcfg(8'h5A);
      check("R1 readback", 32'(cfg_rdata), 32'h5A);

      // Exhaustive sweep: mode x class x handshake, level mode, active high
      for (int m = 0; m < 4; m++) begin
         for (int c = 0; c < 3; c++) begin
            for (int k = 0; k < 3; k++) begin
               wcfg({2'(m), 2'(m), 2'(m), 2'b01});
               arm();
               e = exp_rep(m, c, k, m_armed[c]);
               hs(2'(c), 2'(k));
               check($sformatf("R2/R3/R4/R5 first m%0d c%0d k%0d", m, c, k),
                     32'(ep_irq_req), 32'(e) << c);
               check("R8 level pin", 32'(irq_pin), 32'(e));
               clr_all();
               e = exp_rep(m, c, k, m_armed[c]);
               hs(2'(c), 2'(k));
               check($sformatf("R3/R4 repeat m%0d c%0d k%0d", m, c, k),
                     32'(ep_irq_req), 32'(e) << c);
               clr_all();
            end
         end
      end

      // R4: class flags are independent
      wcfg(8'hA9);
      arm();
      hs(2'd1, 2'd1);
      check("R4 IN first NAK", 32'(ep_irq_req), 32'h2);
      hs(2'd2, 2'd1);
      check("R4 OUT still armed", 32'(ep_irq_req), 32'h6);
      clr_all();
      hs(2'd1, 2'd1);
      check("R4 IN repeat suppressed", 32'(ep_irq_req), 32'h0);

      // R6: bus reset disarms
      arm();
      @(negedge clk); bus_reset = 1'b1;
      @(negedge clk); bus_reset = 1'b0;
      hs(2'd0, 2'd1);
      check("R6 NAK after bus reset", 32'(ep_irq_req), 32'h0);

      // R6: bus reset cancels waiting SETUP
      @(negedge clk); setup_tok = 1'b1;
      @(negedge clk); setup_tok = 1'b0; bus_reset = 1'b1;
      @(negedge clk); bus_reset = 1'b0;
      hs(2'd0, 2'd0);
      clr_all();
      hs(2'd2, 2'd1);
      check("R6 SETUP cancelled", 32'(ep_irq_req), 32'h0);

      // R7: report wins over clear, pend holds without clear
      @(negedge clk); hs_valid = 1'b1; hs_class = 2'd2; hs_kind = 2'd0; irq_clear = 3'b100;
      @(negedge clk); hs_valid = 1'b0; irq_clear = 3'b000;
      check("R7 set wins clear", 32'(ep_irq_req), 32'h4);
      repeat (3) @(negedge clk);
      check("R7 held", 32'(ep_irq_req), 32'h4);
      @(negedge clk); irq_clear = 3'b011;
      @(negedge clk); irq_clear = 3'b000;
      check("R7 other clear no effect", 32'(ep_irq_req), 32'h4);
      clr_all();
      check("R7 cleared", 32'(ep_irq_req), 32'h0);

      // R10 polarity high, idle
      check("R10 idle active-high pin", 32'(irq_pin), 32'h0);

      // R9: pulse mode, active low
      wcfg(8'hFE);
      check("R10 idle pulsed active-low", 32'(irq_pin), 32'h1);
      @(negedge clk); hs_valid = 1'b1; hs_class = 2'd0; hs_kind = 2'd0;
      @(negedge clk); hs_valid = 1'b0;
      np = (irq_pin == 1'b0) ? 1 : 0;
      begin
         int rest;
         count_pulse(rest);
         check("R9 pulse width", 32'(np + rest), 32'(PULSE_CYC));
      end
      clr_all();
      // merged pulse: second report two cycles later
      @(negedge clk); hs_valid = 1'b1; hs_class = 2'd1; hs_kind = 2'd0;
      @(negedge clk); hs_valid = 1'b0;
      np = (irq_pin == 1'b0) ? 1 : 0;
      @(negedge clk); hs_valid = 1'b1; hs_class = 2'd2; hs_kind = 2'd0;
      if (irq_pin == 1'b0) np++;
      @(negedge clk); hs_valid = 1'b0;
      if (irq_pin == 1'b0) np++;
      begin
         int rest;
         count_pulse(rest);
         check("R9 merged pulse width", 32'(np + rest), 32'(PULSE_CYC));
      end
      check("R9 pend kept in pulse mode", 32'(ep_irq_req), 32'h6);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule